// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steps an 8-bit processor with a 16-bit address space through the memory traffic of entering a handler. The entry can come from reset, from a non-maskable interrupt, from a maskable interrupt or from a software break. For every source except reset it saves the return address and the status byte on a stack in page one. It then fetches the handler address from the fixed vector slot of the winning source and presents that address as the new program counter, along with a status value that has the interrupt-disable flag set.

The surrounding core raises `boundary` when an instruction has finished. On a cycle where `boundary` is high and the sequencer is idle, it arbitrates among the pending sources and captures `pc_in` and `status_in`. The same engine also performs the three pops of a return-from-interrupt: status, then the low byte of the program counter, then the high byte. Memory is a synchronous single port, and read data arrives one cycle after the read strobe. The stack pointer lives inside the block and is visible on `sp_out`.

Top module: `irq_vector_seq`

## Requirements
- R1: After reset is released, the block writes nothing to memory. It reads 0xFFFC (low byte) and 0xFFFD (high byte). Four cycles after the first edge with `rst_n` high it pulses `done`, with `pc_out` equal to that word, `status_out` = 0x04 and `sp_out` = 0xFD.
- R2: An entry writes three bytes to address 0x0100 + stack pointer: first PC[15:8], then PC[7:0], then the status byte. The pointer is decremented after each write.
- R3: Bit 4 of the pushed status byte is 1 for a software break and 0 for NMI or IRQ. All other bits are copied from `status_in`.
- R4: NMI reads its handler address from 0xFFFA/0xFFFB. IRQ and break read theirs from 0xFFFE/0xFFFF. The low byte is at the lower address.
- R5: When several requests are present on an accepting cycle, the order of priority is NMI, then IRQ, then break, then return.
- R6: `irq_req` is ignored while `status_in` bit 2 is 1. NMI and break are accepted regardless of bit 2.
- R7: Requests are accepted only on a cycle where `boundary` is 1 and `busy` is 0. Requests at any other time have no effect.
- R8: `done` is a one-cycle pulse, and `busy` is 0 in the same cycle. For an entry, `done` rises 7 cycles after the accepting edge, with `pc_out` equal to the vector and `status_out` equal to `status_in` with bit 2 set.
- R9: A return performs three pops, each of which increments the pointer and then reads. The pops fetch status, then PC low, then PC high. `done` rises 5 cycles after the accepting edge, with `pc_out` equal to the popped word and `status_out` equal to the popped status.
- R10: The stack pointer wraps within 8 bits in both directions, and every stack access stays in page one.
- R11: `mem_we` and `mem_re` are never high together, and neither is high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the reset entry |
| boundary | input | 1 | Instruction boundary; requests are sampled when high |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| brk_req | input | 1 | Software break request |
| rti_req | input | 1 | Return-from-interrupt request (stack pops only) |
| pc_in | input | 16 | Return address to save on entry |
| status_in | input | 8 | Current status byte (bit 2 = interrupt disable) |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| status_out | output | 8 | New status byte |
| sp_out | output | 8 | Stack pointer |

## Verification
Entry is exercised with IRQ alone, break alone, all three interrupt sources at once with the disable flag set, and IRQ together with break. Comparing the vector fetched and the B bit pushed in these cases separates the priority order from the masking rule. Further runs give a masked IRQ, a request with `boundary` low, and an NMI raised mid-sequence; each should leave memory and the pointer untouched. A return that starts from the reset pointer wraps through 0xFF to 0x00, and a following IRQ wraps the pointer back down. An IRQ followed by a return shows that the popped bytes match the pushed ones.

// File: rtl/ivs_pkg.sv
// Package: shared types and fixed constants of the interrupt sequencer.
// Assumes an 8-bit data path and a 16-bit address space.
package ivs_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    // status bit positions used by the sequencer
    localparam int ST_I = 2;
    localparam int ST_B = 4;

    // fixed handler vector slots (low byte address)
    localparam logic [ADDR_W-1:0] VEC_NMI   = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RESET = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ   = 16'hFFFE;

    typedef enum logic [3:0] {
        S_BOOT, S_IDLE,
        S_PUSH_H, S_PUSH_L, S_PUSH_P,
        S_VEC_L, S_VEC_H,
        S_POP_P, S_POP_L, S_POP_H,
        S_LOAD
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NONE, K_RESET, K_NMI, K_IRQ, K_BRK, K_RTI
    } src_kind_e;

    // Vector slot for a given entry source.
    function automatic logic [ADDR_W-1:0] vec_base(input src_kind_e k);
        case (k)
            K_NMI:   return VEC_NMI;
            K_RESET: return VEC_RESET;
            default: return VEC_IRQ;
        endcase
    endfunction
endpackage

// File: rtl/ivs_arbiter.sv
// Module: ivs_arbiter
// Picks one request in fixed priority NMI > IRQ > BRK > RTI.
// Assumes requests are levels held by the core; IRQ is gated by the
// interrupt-disable flag, the others are not.
module ivs_arbiter
    import ivs_pkg::*;
(
    input  logic      nmi,
    input  logic      irq,
    input  logic      brk,
    input  logic      rti,
    input  logic      i_flag,
    output src_kind_e pick
);
    // Fixed-priority selection of the winning source.
    always_comb begin
        if (nmi)                 pick = K_NMI;
        else if (irq && !i_flag) pick = K_IRQ;
        else if (brk)            pick = K_BRK;
        else if (rti)            pick = K_RTI;
        else                     pick = K_NONE;
    end
endmodule

// File: rtl/ivs_stack_ptr.sv
// Module: ivs_stack_ptr
// Holds the 8-bit stack pointer. Push post-decrements, pop pre-increments,
// both wrapping within 8 bits. Assumes push and pop are never both high.
module ivs_stack_ptr #(
    parameter int          SP_W     = 8,
    parameter logic [SP_W-1:0] SP_RESET = 8'hFD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up
);
    // Pointer register with wrap-around update.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= SP_RESET;
        else if (push) sp <= sp - 1'b1;
        else if (pop)  sp <= sp + 1'b1;
    end

    // Address a pop reads: the incremented pointer.
    always_comb sp_up = sp + 1'b1;
endmodule

// File: rtl/ivs_bus_drive.sv
// Module: ivs_bus_drive
// Turns the sequencer state into memory port strobes, address and write
// data, plus push/pop pulses for the stack pointer. Purely combinational.
// Assumes the stack lives in page STACK_PAGE.
module ivs_bus_drive
    import ivs_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  seq_state_e        state,
    input  src_kind_e         kind,
    input  logic [7:0]        sp,
    input  logic [7:0]        sp_up,
    input  logic [ADDR_W-1:0] pc_hold,
    input  logic [DATA_W-1:0] st_hold,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              re,
    output logic [DATA_W-1:0] wdata,
    output logic              push,
    output logic              pop
);
    logic [ADDR_W-1:0] vec;
    logic [DATA_W-1:0] st_pushed;

    // Vector slot and the status byte with B replaced by the source type.
    always_comb begin
        vec       = vec_base(kind);
        st_pushed = st_hold;
        st_pushed[ST_B] = (kind == K_BRK);
    end

    // Per-state bus drive.
    always_comb begin
        addr  = '0;
        we    = 1'b0;
        re    = 1'b0;
        wdata = '0;
        push  = 1'b0;
        pop   = 1'b0;
        case (state)
            S_PUSH_H: begin
                we = 1'b1; push = 1'b1; addr = {STACK_PAGE, sp};
                wdata = pc_hold[15:8];
            end
            S_PUSH_L: begin
                we = 1'b1; push = 1'b1; addr = {STACK_PAGE, sp};
                wdata = pc_hold[7:0];
            end
            S_PUSH_P: begin
                we = 1'b1; push = 1'b1; addr = {STACK_PAGE, sp};
                wdata = st_pushed;
            end
            S_VEC_L: begin
                re = 1'b1; addr = vec;
            end
            S_VEC_H: begin
                re = 1'b1; addr = vec | 16'h0001;
            end
            S_POP_P, S_POP_L, S_POP_H: begin
                re = 1'b1; pop = 1'b1; addr = {STACK_PAGE, sp_up};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_vector_seq.sv
// Module: irq_vector_seq (top)
// Sequences reset, NMI, IRQ and break entry (push PC and status, fetch the
// vector) and the three pops of a return. Assumes a synchronous memory
// whose read data is valid the cycle after mem_re, and a core that holds
// requests until it sees busy or done.
module irq_vector_seq
    import ivs_pkg::*;
#(
    parameter logic [7:0] SP_RESET   = 8'hFD,
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              brk_req,
    input  logic              rti_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] status_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] status_out,
    output logic [7:0]        sp_out
);
    seq_state_e        state;
    src_kind_e         kind;
    src_kind_e         pick;
    logic [ADDR_W-1:0] pc_hold;
    logic [DATA_W-1:0] st_hold;
    logic [DATA_W-1:0] lo_byte;
    logic [DATA_W-1:0] pop_st;
    logic [7:0]        sp;
    logic [7:0]        sp_up;
    logic              push;
    logic              pop;

    ivs_arbiter u_arb (
        .nmi    (nmi_req),
        .irq    (irq_req),
        .brk    (brk_req),
        .rti    (rti_req),
        .i_flag (status_in[ST_I]),
        .pick   (pick)
    );

    ivs_stack_ptr #(.SP_W(8), .SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .sp    (sp),
        .sp_up (sp_up)
    );

    ivs_bus_drive #(.STACK_PAGE(STACK_PAGE)) u_bus (
        .state   (state),
        .kind    (kind),
        .sp      (sp),
        .sp_up   (sp_up),
        .pc_hold (pc_hold),
        .st_hold (st_hold),
        .addr    (mem_addr),
        .we      (mem_we),
        .re      (mem_re),
        .wdata   (mem_wdata),
        .push    (push),
        .pop     (pop)
    );

    // Sequencer state, captured context and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_BOOT;
            kind       <= K_RESET;
            pc_hold    <= '0;
            st_hold    <= '0;
            lo_byte    <= '0;
            pop_st     <= '0;
            pc_out     <= '0;
            status_out <= 8'h04;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_BOOT:   state <= S_VEC_L;
                S_IDLE: begin
                    if (boundary && pick != K_NONE) begin
                        kind    <= pick;
                        pc_hold <= pc_in;
                        st_hold <= status_in;
                        state   <= (pick == K_RTI) ? S_POP_P : S_PUSH_H;
                    end
                end
                S_PUSH_H: state <= S_PUSH_L;
                S_PUSH_L: state <= S_PUSH_P;
                S_PUSH_P: state <= S_VEC_L;
                S_VEC_L:  state <= S_VEC_H;
                S_VEC_H: begin
                    lo_byte <= mem_rdata;
                    state   <= S_LOAD;
                end
                S_POP_P:  state <= S_POP_L;
                S_POP_L: begin
                    pop_st <= mem_rdata;
                    state  <= S_POP_H;
                end
                S_POP_H: begin
                    lo_byte <= mem_rdata;
                    state   <= S_LOAD;
                end
                S_LOAD: begin
                    pc_out <= {mem_rdata, lo_byte};
                    done   <= 1'b1;
                    if (kind == K_RTI) begin
                        status_out <= pop_st;
                    end else begin
                        status_out <= st_hold | (8'h01 << ST_I);
                    end
                    state <= S_IDLE;
                end
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Externally visible busy and pointer.
    always_comb begin
        busy   = (state != S_IDLE);
        sp_out = sp;
    end
endmodule

// File: rtl/irq_vector_seq_chk.sv
// Module: irq_vector_seq_chk
// Port-level checker for irq_vector_seq, attached with bind below.
module irq_vector_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        boundary,
    input logic        nmi_req,
    input logic        irq_req,
    input logic        brk_req,
    input logic        rti_req,
    input logic [7:0]  status_in,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        busy,
    input logic        done,
    input logic [7:0]  sp_out
);
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));                                          // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));                               // R11
    AST_WRITE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == 8'h01));                         // R2
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == $past(sp_out) - 8'd1));                  // R10
    AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr[15:8] != 8'h01) |-> (mem_addr >= 16'hFFFA)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                               // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && boundary && irq_req && status_in[2] &&
         !nmi_req && !brk_req && !rti_req) |=> !busy);                 // R6
endmodule

bind irq_vector_seq irq_vector_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .nmi_req   (nmi_req),
    .irq_req   (irq_req),
    .brk_req   (brk_req),
    .rti_req   (rti_req),
    .status_in (status_in),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done),
    .sp_out    (sp_out)
);

// File: tb/irq_vector_seq_bench.sv
module irq_vector_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        nmi_req = 1'b0, irq_req = 1'b0, brk_req = 1'b0, rti_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done;
    logic [15:0] pc_out;
    logic [7:0]  status_out, sp_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]  stk [256];
    logic [15:0] wr_addr [64];
    logic [7:0]  wr_data [64];
    int          wr_n = 0;

    irq_vector_seq u_irq_vector_seq (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .nmi_req(nmi_req), .irq_req(irq_req), .brk_req(brk_req), .rti_req(rti_req),
        .pc_in(pc_in), .status_in(status_in),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pc_out(pc_out),
        .status_out(status_out), .sp_out(sp_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'hC0;
            16'hFFFE: return 8'h78;
            16'hFFFF: return 8'h56;
            default:  return 8'hEE;
        endcase
    endfunction

    // synchronous memory model with a write log
    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : rom(mem_addr);
        if (mem_we) begin
            wr_addr[wr_n % 64] <= mem_addr;
            wr_data[wr_n % 64] <= mem_wdata;
            wr_n <= wr_n + 1;
            if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_reqs();
        boundary = 0; nmi_req = 0; irq_req = 0; brk_req = 0; rti_req = 0;
    endtask

    // reset, release, and count cycles until done
    task automatic do_reset(output int cyc, output int nwr);
        int base;
        @(negedge clk);
        clear_reqs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        base = wr_n;
        rst_n = 1;
        cyc = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cyc++;
            if (done) break;
        end
        nwr = wr_n - base;
    endtask

    // present one request set at a boundary and wait for done
    task automatic run_seq(input logic n, input logic i, input logic b, input logic r,
                           input logic [15:0] pc, input logic [7:0] st,
                           output int cyc, output int base);
        @(negedge clk);
        base = wr_n;
        nmi_req = n; irq_req = i; brk_req = b; rti_req = r;
        pc_in = pc; status_in = st; boundary = 1;
        @(negedge clk);
        clear_reqs();
        cyc = 1;
        if (!done) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                cyc++;
                if (done) break;
            end
        end
    endtask

    task automatic t_reset();
        int cyc, nwr;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R1 done low in reset", done, 0);
        chk("R1 sp in reset", sp_out, 8'hFD);
        do_reset(cyc, nwr);
        chk("R1 reset latency", cyc, 4);
        chk("R1 reset vector", pc_out, 16'hC000);
        chk("R1 reset status", status_out, 8'h04);
        chk("R1 no writes", nwr, 0);
        chk("R1 sp after", sp_out, 8'hFD);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
    endtask

    task automatic t_irq_and_return();
        int cyc, nwr, base;
        do_reset(cyc, nwr);
        run_seq(0, 1, 0, 0, 16'hABCD, 8'h91, cyc, base);
        chk("R8 entry latency", cyc, 7);
        chk("R8 busy low at done", busy, 0);
        chk("R2 write count", wr_n - base, 3);
        chk("R2 push1 addr", wr_addr[base % 64], 16'h01FD);
        chk("R2 push1 pch", wr_data[base % 64], 8'hAB);
        chk("R2 push2 addr", wr_addr[(base+1) % 64], 16'h01FC);
        chk("R2 push2 pcl", wr_data[(base+1) % 64], 8'hCD);
        chk("R2 push3 addr", wr_addr[(base+2) % 64], 16'h01FB);
        chk("R3 irq pushed B=0", wr_data[(base+2) % 64], 8'h81);
        chk("R4 irq vector", pc_out, 16'h5678);
        chk("R8 status I set", status_out, 8'h95);
        chk("R2 sp after entry", sp_out, 8'hFA);
        run_seq(0, 0, 0, 1, 16'h0000, 8'h00, cyc, base);
        chk("R9 return latency", cyc, 5);
        chk("R9 popped pc", pc_out, 16'hABCD);
        chk("R9 popped status", status_out, 8'h81);
        chk("R9 sp restored", sp_out, 8'hFD);
        chk("R9 no writes on return", wr_n - base, 0);
    endtask

    task automatic t_brk();
        int cyc, nwr, base;
        do_reset(cyc, nwr);
        run_seq(0, 0, 1, 0, 16'h2000, 8'h00, cyc, base);
        chk("R3 brk pushed B=1", wr_data[(base+2) % 64], 8'h10);
        chk("R4 brk vector", pc_out, 16'h5678);
        chk("R8 brk status", status_out, 8'h04);
    endtask

    task automatic t_priority();
        int cyc, nwr, base;
        do_reset(cyc, nwr);
        run_seq(1, 1, 1, 1, 16'h3000, 8'h04, cyc, base);
        chk("R5 nmi wins vector", pc_out, 16'h1234);
        chk("R6 nmi ignores I, B=0", wr_data[(base+2) % 64], 8'h04);
        do_reset(cyc, nwr);
        run_seq(0, 1, 1, 1, 16'h3000, 8'h00, cyc, base);
        chk("R5 irq beats brk B=0", wr_data[(base+2) % 64], 8'h00);
        do_reset(cyc, nwr);
        run_seq(0, 0, 1, 1, 16'h3000, 8'h00, cyc, base);
        chk("R5 brk beats return writes", wr_n - base, 3);
    endtask

    task automatic t_ignore();
        int cyc, nwr, base;
        do_reset(cyc, nwr);
        base = wr_n;
        @(negedge clk);
        irq_req = 1; status_in = 8'h04; boundary = 1;
        repeat (5) begin
            @(negedge clk);
            chk("R6 masked irq not busy", busy, 0);
        end
        clear_reqs();
        chk("R6 masked irq no writes", wr_n - base, 0);
        chk("R6 masked irq sp", sp_out, 8'hFD);
        @(negedge clk);
        nmi_req = 1; irq_req = 1; boundary = 0;
        repeat (5) begin
            @(negedge clk);
            chk("R7 no boundary not busy", busy, 0);
        end
        clear_reqs();
        chk("R7 no boundary no writes", wr_n - base, 0);
        run_seq(0, 0, 1, 0, 16'h4000, 8'h04, cyc, base);
        chk("R6 brk taken with I set", pc_out, 16'h5678);
        // request raised mid-sequence must not be taken
        @(negedge clk);
        base = wr_n;
        irq_req = 1; status_in = 8'h00; pc_in = 16'h5555; boundary = 1;
        @(negedge clk);
        irq_req = 0; nmi_req = 1;
        repeat (3) @(negedge clk);
        clear_reqs();
        for (int k = 0; k < 20; k++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R7 mid-run nmi ignored vector", pc_out, 16'h5678);
        chk("R7 mid-run nmi ignored writes", wr_n - base, 3);
    endtask

    task automatic t_wrap();
        int cyc, nwr, base;
        do_reset(cyc, nwr);
        stk[8'hFE] = 8'hC3; stk[8'hFF] = 8'h34; stk[8'h00] = 8'h12;
        run_seq(0, 0, 0, 1, 16'h0000, 8'h00, cyc, base);
        chk("R10 pop wrap pc", pc_out, 16'h1234);
        chk("R10 pop wrap status", status_out, 8'hC3);
        chk("R10 pop wrap sp", sp_out, 8'h00);
        run_seq(0, 1, 0, 0, 16'hBEEF, 8'h00, cyc, base);
        chk("R10 push at 0100", wr_addr[base % 64], 16'h0100);
        chk("R10 push wrap to 01FF", wr_addr[(base+1) % 64], 16'h01FF);
        chk("R10 push wrap data", wr_data[(base+1) % 64], 8'hEF);
        chk("R10 sp after wrap", sp_out, 8'hFD);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 256; k++) stk[k] = 8'h00;
        t_reset();
        t_irq_and_return();
        t_brk();
        t_priority();
        t_ignore();
        t_wrap();
        finish_run();
    end
endmodule